// File: doc/BRIEF.md
# Ping-Pong Page Address Generator

This block produces quadlet addresses for moving synchronous frame data between a streaming port and host memory. The memory area is split into two pages of equal length that sit next to each other. Page 0 starts at a configured base. Page 1 starts one page length above it. Each data strobe moves the address forward by one quadlet. At the end of a page, addressing moves to the other page. After the last quadlet of page 1, addressing returns to the base.

A level control input runs and halts the engine. Each new run starts again from page 0 at the base. The page in use is shown on a live output. Every page change raises a one-cycle event that the interrupt logic can count or latch. The block also has a byte-order stage for the data path. It reverses the four bytes of a quadlet when big-endian order is selected and passes the quadlet through unchanged otherwise. The memory bus master, the frame timing and the network interface are outside this block.

Top module: `pp_page_agen`

## Requirements
- R1: After reset, addr_o is 0, page_o is 0 and flip_o is 0. The page length is 15 quadlets, one frame, and the base is 0.
- R2: In the cycle after run_i rises, addr_o equals the base and page_o is 0, whatever state the engine was in before. A strobe in the cycle where run_i rises is not counted.
- R3: While run_i stays high, each strobe_i moves addr_o up by exactly one in the next cycle, as long as the page end is not reached.
- R4: The strobe that completes page 0 moves addr_o to base + page length and sets page_o to 1.
- R5: The strobe that completes page 1 moves addr_o back to the base and sets page_o to 0.
- R6: flip_o is high for exactly the one cycle after each page-completing strobe. This holds in both directions. A second flip on the very next strobe keeps flip_o high for a second cycle.
- R7: While run_i is low, strobe_i has no effect. addr_o and page_o hold their values.
- R8: cfg_we_i loads the base from cfg_base_i and the page length from cfg_size_i only while run_i is low. While run_i is high, the write is ignored.
- R9: When be_sel_i is 1, data_o is data_i with its four bytes in reverse order (data_i[31:24] appears on data_o[7:0]). When be_sel_i is 0, data_o equals data_i. This path is combinational.
- R10: A page length of 0 written through cfg_we_i is stored as 1. With length 1, every strobe flips the page.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Load base and page length |
| cfg_base_i | input | ADDR_W | Base quadlet address of page 0 |
| cfg_size_i | input | SIZE_W | Page length in quadlets |
| run_i | input | 1 | Start (1) / stop (0) control |
| be_sel_i | input | 1 | 1 selects big-endian (byte-reversed) quadlets |
| strobe_i | input | 1 | One quadlet transferred |
| data_i | input | 32 | Quadlet from the data source |
| data_o | output | 32 | Quadlet in the selected byte order |
| addr_o | output | ADDR_W | Current quadlet address |
| page_o | output | 1 | Page currently in use |
| flip_o | output | 1 | One-cycle page-change event |

## Verification
The bench goes after the page edges first. An off-by-one in the end-of-page compare would flip one quadlet early or late, which shows up as a wrong address after exactly page-length strobes. A missing wrap would run past page 1 instead of returning to the base. It checks that a restart from the middle of page 1 lands on page 0, because a design that only cleared the offset would resume at the wrong page. It writes configuration during a run and strobes while halted, which catches an unlocked register or a counter that is not gated. The smallest page length is also covered: a length of 0 written as the page size, and back-to-back flips, where a design that pulses flip_o with an edge detector would drop the second event.

// File: rtl/pp_pkg.sv
package pp_pkg;
  localparam int unsigned ADDR_W_DEF     = 24;
  localparam int unsigned SIZE_W_DEF     = 12;
  localparam int unsigned QUAD_W         = 32;
  localparam int unsigned FRAME_QUADS    = 60 / 4;
endpackage

// File: rtl/pp_cfg_regs.sv
module pp_cfg_regs #(
  parameter int unsigned ADDR_W   = 24,
  parameter int unsigned SIZE_W   = 12,
  parameter int unsigned RST_SIZE = 15
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic              lock_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [SIZE_W-1:0] size_i,
  output logic [ADDR_W-1:0] base_o,
  output logic [SIZE_W-1:0] size_o
);
  localparam logic [SIZE_W-1:0] SIZE_MIN = SIZE_W'(1);

  logic [ADDR_W-1:0] base_q;
  logic [SIZE_W-1:0] size_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q <= '0;
      size_q <= SIZE_W'(RST_SIZE);
    end else if (we_i && !lock_i) begin
      base_q <= base_i;
      size_q <= (size_i == '0) ? SIZE_MIN : size_i;
    end
  end

  assign base_o = base_q;
  assign size_o = size_q;

  assert_cfg_locked_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_i |=> ($stable(base_q) && $stable(size_q)));

  assert_size_nonzero_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $changed(size_q) |-> (size_q != '0));
endmodule

// File: rtl/pp_page_seq.sv
module pp_page_seq #(
  parameter int unsigned ADDR_W = 24,
  parameter int unsigned SIZE_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  logic              strobe_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [SIZE_W-1:0] size_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              page_o,
  output logic              flip_o
);
  logic              run_q;
  logic              page_q;
  logic              flip_q;
  logic [SIZE_W-1:0] offset_q;
  logic              start;
  logic              adv;
  logic              last;

  assign start = run_i && !run_q;
  assign adv   = run_i && run_q && strobe_i;
  assign last  = (offset_q == size_i - SIZE_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q    <= 1'b0;
      page_q   <= 1'b0;
      flip_q   <= 1'b0;
      offset_q <= '0;
    end else begin
      run_q  <= run_i;
      flip_q <= adv && last;
      if (start) begin
        page_q   <= 1'b0;
        offset_q <= '0;
      end else if (adv) begin
        if (last) begin
          offset_q <= '0;
          page_q   <= ~page_q;
        end else begin
          offset_q <= offset_q + SIZE_W'(1);
        end
      end
    end
  end

  // page 1 sits one page length above the base
  assign addr_o = base_i + (page_q ? ADDR_W'(size_i) : '0) + ADDR_W'(offset_q);
  assign page_o = page_q;
  assign flip_o = flip_q;

  assert_offset_in_page_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q |-> (offset_q < size_i));

  assert_wrap_to_base_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(page_q) |-> (offset_q == '0));

  assert_flip_tracks_page_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flip_q |-> (page_q != $past(page_q)));

  assert_hold_when_idle_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> ($stable(offset_q) && $stable(page_q)));
endmodule

// File: rtl/pp_byte_order.sv
module pp_byte_order #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              be_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] data_o
);
  localparam int unsigned NB = DATA_W / 8;

  logic [DATA_W-1:0] swapped;

  for (genvar g = 0; g < NB; g++) begin : g_lane
    assign swapped[8*g +: 8] = data_i[8*(NB-1-g) +: 8];
  end

  assign data_o = be_i ? swapped : data_i;

  always_comb begin
    if (!be_i) assert_le_passthru_R9: assert (data_o == data_i);
  end
endmodule

// File: rtl/pp_page_agen.sv
module pp_page_agen
  import pp_pkg::*;
#(
  parameter int unsigned ADDR_W   = ADDR_W_DEF,
  parameter int unsigned SIZE_W   = SIZE_W_DEF,
  parameter int unsigned RST_SIZE = FRAME_QUADS
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [ADDR_W-1:0] cfg_base_i,
  input  logic [SIZE_W-1:0] cfg_size_i,
  input  logic              run_i,
  input  logic              be_sel_i,
  input  logic              strobe_i,
  input  logic [31:0]       data_i,
  output logic [31:0]       data_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              page_o,
  output logic              flip_o
);
  logic [ADDR_W-1:0] base;
  logic [SIZE_W-1:0] size;

  pp_cfg_regs #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W), .RST_SIZE(RST_SIZE)) u_cfg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (cfg_we_i),
    .lock_i (run_i),
    .base_i (cfg_base_i),
    .size_i (cfg_size_i),
    .base_o (base),
    .size_o (size)
  );

  pp_page_seq #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W)) u_seq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .run_i    (run_i),
    .strobe_i (strobe_i),
    .base_i   (base),
    .size_i   (size),
    .addr_o   (addr_o),
    .page_o   (page_o),
    .flip_o   (flip_o)
  );

  pp_byte_order #(.DATA_W(QUAD_W)) u_bo (
    .be_i   (be_sel_i),
    .data_i (data_i),
    .data_o (data_o)
  );
endmodule

// File: tb/pp_page_agen_tb_top.sv
`timescale 1ns/1ps
module pp_page_agen_tb_top;
  localparam int unsigned AW = 24;
  localparam int unsigned SW = 12;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          we = 1'b0, run = 1'b0, be = 1'b0, stb = 1'b0;
  logic [AW-1:0] base_in = '0;
  logic [SW-1:0] size_in = '0;
  logic [31:0]   din = '0, dout;
  logic [AW-1:0] addr;
  logic          page, flip;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  pp_page_agen dut_i (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(we), .cfg_base_i(base_in),
    .cfg_size_i(size_in), .run_i(run), .be_sel_i(be), .strobe_i(stb),
    .data_i(din), .data_o(dout), .addr_o(addr), .page_o(page), .flip_o(flip)
  );

  // {be, data_in, expected}
  localparam logic [64:0] VEC [6] = '{
    {1'b0, 32'h1122_3344, 32'h1122_3344},
    {1'b1, 32'h1122_3344, 32'h4433_2211},
    {1'b1, 32'hA5B6_C7D8, 32'hD8C7_B6A5},
    {1'b0, 32'hA5B6_C7D8, 32'hA5B6_C7D8},
    {1'b1, 32'hFF00_0000, 32'h0000_00FF},
    {1'b1, 32'h0000_0001, 32'h0100_0000}
  };

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive at negedge, let one posedge pass, sample at the next negedge
  task automatic step(logic s);
    stb = s;
    @(posedge clk);
    @(negedge clk);
    stb = 1'b0;
    we  = 1'b0;
  endtask

  task automatic cfg(logic [AW-1:0] b, logic [SW-1:0] s);
    base_in = b; size_in = s; we = 1'b1;
    step(1'b0);
  endtask

  task automatic state(string req, logic [AW-1:0] a, logic p, logic f);
    chk({req, " addr"}, 32'(addr), 32'(a));
    chk({req, " page"}, 32'(page), 32'(p));
    chk({req, " flip"}, 32'(flip), 32'(f));
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 6; i++) begin
      be = VEC[i][64]; din = VEC[i][63:32];
      #1;
      chk("R9 byte order", dout, VEC[i][31:0]);
    end
    be = 1'b0;

    repeat (2) @(negedge clk);
    state("R1 reset", '0, 1'b0, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: default length is one frame of 15 quadlets
    run = 1'b1; step(1'b0);
    state("R2 first start", '0, 1'b0, 1'b0);
    for (int i = 1; i < 15; i++) step(1'b1);
    chk("R3 last quad of page 0", 32'(addr), 32'd14);
    step(1'b1);
    state("R1 R4 default length flip", 24'd15, 1'b1, 1'b1);
    step(1'b0);
    chk("R6 flip single cycle", 32'(flip), 32'd0);

    run = 1'b0; step(1'b0);
    cfg(24'h100, 12'd4);
    run = 1'b1; stb = 1'b1; step(1'b1);
    state("R2 start ignores strobe", 24'h100, 1'b0, 1'b0);
    step(1'b1); chk("R3 advance 1", 32'(addr), 32'h101);
    step(1'b1); chk("R3 advance 2", 32'(addr), 32'h102);
    step(1'b1); chk("R3 advance 3", 32'(addr), 32'h103);
    step(1'b1); state("R4 enter page 1", 24'h104, 1'b1, 1'b1);
    step(1'b0); chk("R6 flip drops", 32'(flip), 32'd0);
    step(1'b1); step(1'b1); step(1'b1);
    chk("R3 last of page 1", 32'(addr), 32'h107);
    step(1'b1); state("R5 wrap to base", 24'h100, 1'b0, 1'b1);
    step(1'b0); chk("R6 flip drops after wrap", 32'(flip), 32'd0);

    cfg(24'h200, 12'd2);
    step(1'b1); chk("R8 base locked", 32'(addr), 32'h101);
    step(1'b1); step(1'b1); step(1'b1);
    state("R8 size locked", 24'h104, 1'b1, 1'b1);
    step(1'b1); chk("R3 page 1 step", 32'(addr), 32'h105);

    run = 1'b0; step(1'b0);
    step(1'b1); step(1'b1); step(1'b1);
    state("R7 idle strobes ignored", 24'h105, 1'b1, 1'b0);
    run = 1'b1; step(1'b0);
    state("R2 restart from page 1", 24'h100, 1'b0, 1'b0);

    run = 1'b0; step(1'b0);
    cfg(24'h40, 12'd0);
    run = 1'b1; step(1'b0);
    state("R10 start", 24'h40, 1'b0, 1'b0);
    step(1'b1); state("R10 length 1 flip", 24'h41, 1'b1, 1'b1);
    stb = 1'b1; step(1'b1);
    state("R6 back to back flip", 24'h40, 1'b0, 1'b1);
    step(1'b0); chk("R6 flip ends", 32'(flip), 32'd0);

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule